// File: doc/BRIEF.md
# Parallel Device Bus Timing Controller

This block runs a multiplexed, asynchronous parallel bus for NOR flash, SRAM or FPGA peripherals. An internal requester hands it a single or burst read or write through a valid/ready port. The controller then produces the chip select, address latch, output enable and write enable strobes, the three low address bits, the shared address/data lines and their pad drive enable. Read samples come back one beat at a time on a valid/data pair.

Every phase is counted in clock ticks. The counts come from one 32-bit timing word that software writes. Most timing values are split across the word: their low bits sit in a packed group and their top bit sits in a separate extension bit. The controller takes a copy of the word when it accepts a request, so a rewrite during an access has no effect on that access. After every read it holds the pads undriven for a programmed turnaround. This keeps a slow device from contending on the bus when the next access starts.

Top module: `pbus_timing_ctrl`

## Requirements
- R1: After synchronous reset, bus_cs_n, bus_oe_n and bus_we_n are high, bus_ale and bus_ad_oe are low, bus_a is 0, req_ready is high and cfg_rdata reads 32'h8000_0000 (every count zero, width code 0).
- R2: A request is accepted on a clock edge where req_valid and req_ready are both high. In the cycle after acceptance bus_cs_n is low and bus_ale is low. In the next cycle bus_ale is high for exactly one cycle, bus_ad_oe is high, bus_ad_out carries the zero-extended request address, and bus_a carries req_addr[2:0] from acceptance onward.
- R3: Read timing. bus_oe_n goes low in the cycle after the bus_ale pulse. The first sample is taken first_gap ticks after bus_ale falls. first_gap is the 5-bit value {bit 23, bits 6:3}. rd_valid pulses in the following cycle with the sampled bus_ad_in. bus_ad_oe stays low while bus_oe_n is low.
- R4: Burst read timing. Each later sample is taken next_gap ticks after the one before. next_gap is the 5-bit value {bit 24, bits 10:7}. bus_a increments modulo 8 for each beat. bus_cs_n and bus_oe_n rise at the edge of the last sample. req_len gives the beat count minus one.
- R5: Read turnaround. After the last sample, bus_ad_oe stays low and req_ready stays low for idle_gap ticks. idle_gap is the 4-bit value {bit 22, bits 2:0}. No request is accepted during this time.
- R6: Write timing. bus_we_n falls setup_gap ticks after bus_ale falls, where setup_gap is {bit 25, bits 13:11}. It stays low for low_gap ticks, where low_gap is {bit 26, bits 16:14}. Beat-0 data (req_wdata[DW-1:0]) and bus_a stay stable from the fall of bus_ale to the rise of bus_we_n. bus_cs_n rises together with the last rise of bus_we_n.
- R7: Burst write timing. Between beats, bus_we_n stays high for high_gap ticks, where high_gap is {bit 27, bits 19:17}. The previous beat's data and address are held during that time. Beat i drives req_wdata[i*DW +: DW], and bus_a advances by one per beat.
- R8: A timing count of zero lasts one tick, so every phase is at least one clock long.
- R9: Width code bits 21:20 select the active data lanes: 0 selects bits 7:0, 1 selects bits 15:0, and 2 or 3 select all 32 bits. Unselected lanes of bus_ad_out and of rd_data are zero.
- R10: cfg_rdata returns bits 29:0 as last written, and bits 31:30 always read as binary 10.
- R11: A timing word written in the same cycle as an acceptance, or at any time during an access, affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the timing word |
| cfg_wdata | input | 32 | Timing word to write |
| cfg_rdata | output | 32 | Timing word readback |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, can accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Device address |
| req_len | input | LENW | Beats minus one |
| req_wdata | input | MAX_BEATS*DW | Write data, beat i in slice i |
| rd_valid | output | 1 | One-cycle pulse per read sample |
| rd_data | output | DW | Sampled read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_ale | output | 1 | Address latch enable, active high |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_a | output | 3 | Low address bits, per beat |
| bus_ad_out | output | DW | Value driven onto the shared lines |
| bus_ad_oe | output | 1 | Pad drive enable for the shared lines |
| bus_ad_in | input | DW | Value read from the shared lines |

## Verification
Two things can land on the same edge: a software write of the timing word and the acceptance of a request. The bench provokes this by raising cfg_wr and req_valid in the same cycle while req_ready is high. It then judges every strobe cycle of that access against the old word and every later access against the new one. It also rewrites the word in the middle of a burst and holds the next request pending through the turnaround, checking that neither the running access nor the gap is cut short.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CSU, ST_ALE, ST_RACC, ST_TURN, ST_WSU, ST_WLO, ST_WHI
  } pbus_state_e;

  typedef struct packed {
    logic [4:0] first_gap;
    logic [4:0] next_gap;
    logic [3:0] idle_gap;
    logic [3:0] setup_gap;
    logic [3:0] low_gap;
    logic [3:0] high_gap;
    logic [1:0] width;
  } pbus_timing_t;

  // Gather each split field: extension bit on top, packed low bits below.
  function automatic pbus_timing_t unpack_timing(input logic [31:0] w);
    pbus_timing_t t;
    t.idle_gap  = {w[22], w[2:0]};
    t.first_gap = {w[23], w[6:3]};
    t.next_gap  = {w[24], w[10:7]};
    t.setup_gap = {w[25], w[13:11]};
    t.low_gap   = {w[26], w[16:14]};
    t.high_gap  = {w[27], w[19:17]};
    t.width     = w[21:20];
    return t;
  endfunction

  // Counter preload: a zero count still lasts one tick.
  function automatic logic [4:0] preload(input logic [4:0] n);
    return (n == 5'd0) ? 5'd0 : n - 5'd1;
  endfunction

endpackage

// File: rtl/pbus_cfg_reg.sv
module pbus_cfg_reg #(
  parameter logic [31:0] RST_VAL = 32'h8000_0000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [31:0]           wr_data,
  input  logic                  snap,
  output logic [31:0]           rdata,
  output pbus_pkg::pbus_timing_t active
);
  logic [29:0] body;

  always_ff @(posedge clk) begin
    if (rst)        body <= RST_VAL[29:0];
    else if (wr_en) body <= wr_data[29:0];
  end

  assign rdata = {2'b10, body};

  // Snapshot taken at acceptance; the running access never sees a rewrite.
  always_ff @(posedge clk) begin
    if (rst)       active <= pbus_pkg::unpack_timing(RST_VAL);
    else if (snap) active <= pbus_pkg::unpack_timing(rdata);
  end
endmodule

// File: rtl/pbus_phase_cnt.sv
module pbus_phase_cnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/pbus_lane_mask.sv
module pbus_lane_mask #(
  parameter int DW = 32
) (
  input  logic [1:0]    width,
  output logic [DW-1:0] mask
);
  localparam int LANES = DW / 8;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask[i*8 +: 8] = {8{(32'(i) < (32'd1 << width))}};
  end
endmodule

// File: rtl/pbus_timing_ctrl.sv
module pbus_timing_ctrl #(
  parameter int          DW        = 32,
  parameter int          AW        = 24,
  parameter int          MAX_BEATS = 4,
  parameter int          LENW      = $clog2(MAX_BEATS),
  parameter logic [31:0] CFG_RST   = 32'h8000_0000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_wr,
  input  logic [31:0]             cfg_wdata,
  output logic [31:0]             cfg_rdata,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [AW-1:0]           req_addr,
  input  logic [LENW-1:0]         req_len,
  input  logic [MAX_BEATS*DW-1:0] req_wdata,
  output logic                    rd_valid,
  output logic [DW-1:0]           rd_data,
  output logic                    bus_cs_n,
  output logic                    bus_ale,
  output logic                    bus_oe_n,
  output logic                    bus_we_n,
  output logic [2:0]              bus_a,
  output logic [DW-1:0]           bus_ad_out,
  output logic                    bus_ad_oe,
  input  logic [DW-1:0]           bus_ad_in
);
  import pbus_pkg::*;

  localparam int PADW = DW - AW;

  pbus_state_e            state, nxt;
  pbus_timing_t           tm;
  logic                   accept, cnt_load, cnt_done, beat_inc, sample;
  logic [4:0]             cnt_val;
  logic [DW-1:0]          mask, addr_ext;
  logic [AW-1:0]          addr_q;
  logic [LENW-1:0]        len_q, beat, beat_nx;
  logic                   wr_q;
  logic [MAX_BEATS*DW-1:0] wdata_q;

  assign accept   = req_valid && req_ready;
  assign beat_nx  = beat_inc ? beat + 1'b1 : beat;
  assign addr_ext = {{PADW{1'b0}}, addr_q};

  pbus_cfg_reg #(.RST_VAL(CFG_RST)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .wr_data(cfg_wdata),
    .snap(accept), .rdata(cfg_rdata), .active(tm)
  );

  pbus_phase_cnt #(.W(5)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val), .done(cnt_done)
  );

  pbus_lane_mask #(.DW(DW)) u_mask (.width(tm.width), .mask(mask));

  always_comb begin
    nxt      = state;
    cnt_load = 1'b0;
    cnt_val  = '0;
    beat_inc = 1'b0;
    sample   = 1'b0;
    unique case (state)
      ST_IDLE: if (accept) nxt = ST_CSU;
      ST_CSU:  nxt = ST_ALE;
      ST_ALE: begin
        cnt_load = 1'b1;
        if (wr_q) begin
          nxt     = ST_WSU;
          cnt_val = preload({1'b0, tm.setup_gap});
        end else begin
          nxt     = ST_RACC;
          cnt_val = preload(tm.first_gap);
        end
      end
      ST_RACC: if (cnt_done) begin
        sample   = 1'b1;
        cnt_load = 1'b1;
        if (beat == len_q) begin
          nxt     = ST_TURN;
          cnt_val = preload({1'b0, tm.idle_gap});
        end else begin
          beat_inc = 1'b1;
          cnt_val  = preload(tm.next_gap);
        end
      end
      ST_TURN: if (cnt_done) nxt = ST_IDLE;
      ST_WSU: if (cnt_done) begin
        nxt      = ST_WLO;
        cnt_load = 1'b1;
        cnt_val  = preload({1'b0, tm.low_gap});
      end
      ST_WLO: if (cnt_done) begin
        if (beat == len_q) begin
          nxt = ST_IDLE;
        end else begin
          nxt      = ST_WHI;
          cnt_load = 1'b1;
          cnt_val  = preload({1'b0, tm.high_gap});
        end
      end
      ST_WHI: if (cnt_done) begin
        nxt      = ST_WLO;
        beat_inc = 1'b1;
        cnt_load = 1'b1;
        cnt_val  = preload({1'b0, tm.low_gap});
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      req_ready  <= 1'b1;
      bus_cs_n   <= 1'b1;
      bus_ale    <= 1'b0;
      bus_oe_n   <= 1'b1;
      bus_we_n   <= 1'b1;
      bus_ad_oe  <= 1'b0;
      bus_ad_out <= '0;
      bus_a      <= '0;
      beat       <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      addr_q     <= '0;
      len_q      <= '0;
      wr_q       <= 1'b0;
      wdata_q    <= '0;
    end else begin
      state     <= nxt;
      req_ready <= (nxt == ST_IDLE);
      bus_cs_n  <= (nxt == ST_IDLE) || (nxt == ST_TURN);
      bus_ale   <= (nxt == ST_ALE);
      bus_oe_n  <= (nxt != ST_RACC);
      bus_we_n  <= (nxt != ST_WLO);
      bus_ad_oe <= (nxt == ST_ALE) || (nxt == ST_WSU) ||
                   (nxt == ST_WLO) || (nxt == ST_WHI);
      unique case (nxt)
        ST_ALE:                 bus_ad_out <= addr_ext & mask;
        ST_WSU, ST_WLO, ST_WHI: bus_ad_out <= wdata_q[beat_nx*DW +: DW] & mask;
        default:                bus_ad_out <= '0;
      endcase
      if (accept) begin
        addr_q  <= req_addr;
        len_q   <= req_len;
        wr_q    <= req_write;
        wdata_q <= req_wdata;
        beat    <= '0;
        bus_a   <= req_addr[2:0];
      end else if (beat_inc) begin
        beat  <= beat_nx;
        bus_a <= bus_a + 3'd1;
      end
      rd_valid <= sample;
      if (sample) rd_data <= bus_ad_in & mask;
    end
  end
endmodule

// File: rtl/pbus_timing_chk.sv
module pbus_timing_chk (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic bus_cs_n,
  input logic bus_ale,
  input logic bus_oe_n,
  input logic bus_we_n,
  input logic bus_ad_oe,
  input logic rd_valid
);
  p_cs_leads_ale_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ale) |-> $past(!bus_cs_n));

  p_ale_single_r2: assert property (@(posedge clk) disable iff (rst)
    bus_ale |=> !bus_ale);

  p_no_drive_on_read_r3: assert property (@(posedge clk) disable iff (rst)
    !bus_oe_n |-> !bus_ad_oe);

  p_sample_under_oe_r3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!bus_oe_n));

  p_read_end_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_oe_n) |-> $rose(bus_cs_n));

  p_turn_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_oe_n) || !bus_oe_n) |=> !req_ready);

  p_we_in_cs_r6: assert property (@(posedge clk) disable iff (rst)
    !bus_we_n |-> (!bus_cs_n && bus_oe_n));

  p_idle_strobes_r1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (bus_cs_n && bus_oe_n && bus_we_n && !bus_ale));
endmodule

bind pbus_timing_ctrl pbus_timing_chk u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .bus_cs_n(bus_cs_n),
  .bus_ale(bus_ale), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
  .bus_ad_oe(bus_ad_oe), .rd_valid(rd_valid)
);

// File: tb/test_pbus_timing_ctrl.sv
module test_pbus_timing_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 24;
  localparam int NB = 4;
  localparam int LW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [NB*DW-1:0] req_wdata = '0;
  logic rd_valid;
  logic [DW-1:0] rd_data, bus_ad_out, bus_ad_in = '0;
  logic bus_cs_n, bus_ale, bus_oe_n, bus_we_n, bus_ad_oe;
  logic [2:0] bus_a;

  pbus_timing_ctrl #(.DW(DW), .AW(AW), .MAX_BEATS(NB)) i_pbus_timing_ctrl (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .bus_cs_n(bus_cs_n), .bus_ale(bus_ale),
    .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_a(bus_a), .bus_ad_out(bus_ad_out),
    .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic cs_n, ale, oe_n, we_n, ad_oe, rdv, busy;
    logic [2:0] a;
    logic [31:0] out, mask;
    string tag;
  } rec_t;

  rec_t   q[$];
  logic [31:0] mcfg = 32'h8000_0000;
  logic [2:0]  last_a = '0;
  int checks = 0, errors = 0, n_acc = 0, cyc = 0;
  string cur_tag = "R1";

  function automatic int ticks(input logic [4:0] n);
    return (n == 0) ? 1 : int'(n);
  endfunction

  function automatic logic [31:0] mk_cfg(input int fg, ng, ig, sg, lg, hg, wd, sk);
    logic [31:0] r = 32'h8000_0000;
    r[2:0] = 3'(ig);   r[22] = ig[3];
    r[6:3] = 4'(fg);   r[23] = fg[4];
    r[10:7] = 4'(ng);  r[24] = ng[4];
    r[13:11] = 3'(sg); r[25] = sg[3];
    r[16:14] = 3'(lg); r[26] = lg[3];
    r[19:17] = 3'(hg); r[27] = hg[3];
    r[21:20] = 2'(wd); r[29:28] = 2'(sk);
    return r;
  endfunction

  function automatic rec_t mk(input logic cs, al, oe, we, doe, rv,
                              input logic [2:0] a, input logic [31:0] o, m, input string t);
    rec_t r;
    r.cs_n = cs; r.ale = al; r.oe_n = oe; r.we_n = we; r.ad_oe = doe; r.rdv = rv;
    r.busy = 1'b1; r.a = a; r.out = o; r.mask = m; r.tag = t;
    return r;
  endfunction

  // Expand one accepted request into its expected cycle-by-cycle timeline.
  task automatic expand(input bit wr, input logic [AW-1:0] ad, input int len,
                        input logic [NB*DW-1:0] wd, input logic [31:0] c);
    int fg = ticks({c[23], c[6:3]});
    int ng = ticks({c[24], c[10:7]});
    int ig = ticks({1'b0, c[22], c[2:0]});
    int sg = ticks({1'b0, c[25], c[13:11]});
    int lg = ticks({1'b0, c[26], c[16:14]});
    int hg = ticks({1'b0, c[27], c[19:17]});
    logic [31:0] m = (c[21:20] == 2'd0) ? 32'h0000_00FF :
                     (c[21:20] == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    logic [2:0] a0 = ad[2:0];
    q.push_back(mk(0, 0, 1, 1, 0, 0, a0, 32'h0, m, "R2"));
    q.push_back(mk(0, 1, 1, 1, 1, 0, a0, {8'h0, ad} & m, m, "R2"));
    if (!wr) begin
      for (int i = 0; i <= len; i++) begin
        int n = (i == 0) ? fg : ng;
        for (int k = 0; k < n; k++)
          q.push_back(mk(0, 0, 0, 1, 0, (k == 0 && i > 0), 3'(a0 + i), 32'h0, m,
                         (i == 0) ? "R3" : "R4"));
      end
      for (int k = 0; k < ig; k++)
        q.push_back(mk(1, 0, 1, 1, 0, (k == 0), 3'(a0 + len), 32'h0, m, "R5"));
    end else begin
      for (int k = 0; k < sg; k++)
        q.push_back(mk(0, 0, 1, 1, 1, 0, a0, wd[31:0] & m, m, "R6"));
      for (int i = 0; i <= len; i++) begin
        logic [31:0] d = wd[i*DW +: DW] & m;
        for (int k = 0; k < lg; k++)
          q.push_back(mk(0, 0, 1, 0, 1, 0, 3'(a0 + i), d, m, (i == 0) ? "R6" : "R7"));
        if (i < len)
          for (int k = 0; k < hg; k++)
            q.push_back(mk(0, 0, 1, 1, 1, 0, 3'(a0 + i), d, m, "R7"));
      end
    end
  endtask

  // Reference model: advances on the clock edge using pre-edge values.
  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      mcfg = 32'h8000_0000;
    end else begin
      if (req_valid && req_ready) begin
        expand(req_write, req_addr, int'(req_len), req_wdata, mcfg);
        n_acc++;
      end
      if (cfg_wr) mcfg = {2'b10, cfg_wdata[29:0]};
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) %s: actual %h expected %h at cycle %0d", req, cur_tag, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    rec_t e;
    cyc++;
    if (!rst) begin
      if (q.size() > 0) e = q.pop_front();
      else begin
        e = mk(1, 0, 1, 1, 0, 0, last_a, 32'h0, 32'h0, "R1");
        e.busy = 1'b0;
      end
      last_a = e.a;
      chk(bus_cs_n === e.cs_n, e.tag, "cs_n", 32'(bus_cs_n), 32'(e.cs_n));
      chk(bus_ale === e.ale, e.tag, "ale", 32'(bus_ale), 32'(e.ale));
      chk(bus_oe_n === e.oe_n, e.tag, "oe_n", 32'(bus_oe_n), 32'(e.oe_n));
      chk(bus_we_n === e.we_n, e.tag, "we_n", 32'(bus_we_n), 32'(e.we_n));
      chk(bus_ad_oe === e.ad_oe, e.tag, "ad_oe", 32'(bus_ad_oe), 32'(e.ad_oe));
      chk(bus_a === e.a, e.tag, "addr_low", 32'(bus_a), 32'(e.a));
      chk(bus_ad_out === e.out, e.tag, "ad_out", bus_ad_out, e.out);
      chk(req_ready === !e.busy, e.tag, "ready", 32'(req_ready), 32'(!e.busy));
      chk(rd_valid === e.rdv, e.tag, "rd_valid", 32'(rd_valid), 32'(e.rdv));
      if (e.rdv) chk(rd_data === (bus_ad_in & e.mask), e.tag, "rd_data", rd_data, bus_ad_in & e.mask);
      chk(cfg_rdata === {2'b10, mcfg[29:0]}, "R10", "cfg_rdata", cfg_rdata, {2'b10, mcfg[29:0]});
    end
    bus_ad_in = (32'(cyc) * 32'h9E37_79B9) ^ 32'h5A3C_0F17;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      finish_run();
    end
  end

  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Issue a request; returns right after it is accepted.
  task automatic issue(input bit wr, input logic [AW-1:0] ad, input int len,
                       input logic [NB*DW-1:0] wd);
    int start = n_acc;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = ad; req_len = LW'(len); req_wdata = wd;
    while (n_acc == start) @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (q.size() > 0);
    repeat (2) @(negedge clk);
  endtask

  localparam logic [NB*DW-1:0] WD0 = 128'hD4C3_B2A1_8877_6655_1122_3344_A5F0_C3E1;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);                 // R1 reset state compared here
    cur_tag = "R3";
    write_cfg(mk_cfg(3, 2, 2, 2, 3, 2, 2, 0));
    issue(0, 24'h12_3450, 0, WD0);
    cur_tag = "R4";
    issue(0, 24'h00_0006, 3, WD0);             // bus_a wraps 6,7,0,1
    cur_tag = "R5";
    issue(1, 24'h00_0011, 0, WD0);             // queued through the read turnaround
    drain();
    cur_tag = "R7";
    issue(1, 24'h0A_0002, 2, WD0);
    drain();
    cur_tag = "R6";                            // extension bits on every field
    write_cfg(mk_cfg(17, 18, 9, 9, 10, 8, 2, 3));
    issue(0, 24'h00_0003, 1, WD0);
    issue(1, 24'h00_0005, 1, WD0);
    drain();
    cur_tag = "R8";                            // all counts zero
    write_cfg(mk_cfg(0, 0, 0, 0, 0, 0, 3, 0));
    issue(0, 24'h00_0001, 1, WD0);
    issue(1, 24'h00_0007, 1, WD0);
    drain();
    cur_tag = "R9";                            // narrow lanes
    write_cfg(mk_cfg(2, 1, 1, 1, 2, 1, 0, 0));
    issue(0, 24'hAB_CDEF, 2, WD0);
    issue(1, 24'hAB_CDEF, 1, WD0);
    drain();
    write_cfg(mk_cfg(1, 2, 1, 2, 1, 1, 1, 1));
    issue(0, 24'h76_5432, 1, WD0);
    issue(1, 24'h76_5432, 1, WD0);
    drain();
    cur_tag = "R10";
    write_cfg(32'h4FFF_FFFF);                  // top bits written 01, read as 10
    drain();
    cur_tag = "R11";                           // cfg write and acceptance on one edge
    write_cfg(mk_cfg(2, 2, 3, 2, 2, 2, 2, 0));
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = mk_cfg(6, 5, 7, 5, 6, 4, 2, 0);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 24'h00_0004; req_len = 2'd2;
    @(negedge clk);
    cfg_wr = 1'b0; req_valid = 1'b0;
    write_cfg(mk_cfg(1, 1, 1, 1, 1, 1, 0, 0)); // rewrite during the running burst
    issue(1, 24'h00_0002, 3, WD0);
    write_cfg(mk_cfg(4, 4, 4, 4, 4, 4, 2, 0)); // rewrite during the write burst
    drain();
    issue(0, 24'h00_0000, 0, WD0);
    drain();
    finish_run();
  end
endmodule